// File: doc/BRIEF.md
# Keyed Window Deadman Timer

This block is a deadman timer that sits on a simple memory-mapped register bus. Once it is enabled, it counts timer events presented on a tick input. Software must clear it before the count reaches a fixed limit, and clearing takes two keyed writes in order. The first write, the arming key, goes to the pre-clear register. The second write, the confirm key, goes to the clear register and is accepted only while the clear window is open. The window covers the last stretch of the count, from the limit minus the window length up to the limit.

Three things raise an event: a wrong arming key, a confirm key that comes at the wrong time or carries the wrong value, and a count that reaches the limit. An event sets sticky status flags, drives a one-cycle timeout pulse, restarts the count and latches a reset-cause bit. The reset-cause bit stays set until software clears it.

The sequencer has four states:
- OFF: idle and disabled.
- ARMED: counting and waiting for the arming key.
- KEYED: arming key accepted, waiting for the confirm key.
- HOLD: the single dead cycle that follows disabling.

Its transitions are:
- OFF to ARMED on enable.
- ARMED to KEYED on a correct arming key.
- KEYED to KEYED on a repeated correct arming key.
- KEYED to ARMED on a good confirm (clear).
- ARMED or KEYED to ARMED on any event (re-arm).
- ARMED or KEYED to HOLD on disable.
- HOLD to OFF unconditionally.

Top module: `keyed_window_timer`

## Requirements
- R1: After reset the timer is disabled. The control, status, count and cause registers read 0 and both `timeout_o` and `rst_cause_o` are low.
- R2: Control bit 15 is the enable. `bus_op` selects how a write applies the written bit: 0 loads it, 1 sets the enable where the written bit is 1, 2 clears the enable where the written bit is 1, and 3 is ignored. Enabling restarts the count at 0.
- R3: While enabled, the count at offset 0x40 rises by one for each cycle in which `tick` is high, and it never exceeds LIMIT_CNT-1. Offset 0x60 reads LIMIT_CNT and offset 0x70 reads WIN_CNT.
- R4: Status bit 0 reads 1 exactly when the timer is enabled and the count is at least LIMIT_CNT-WIN_CNT.
- R5: A write to offset 0x10 with bits 15:8 equal to 0x40, followed by a write to offset 0x20 with bits 7:0 equal to 0x08 while the window is open, has three effects. The count returns to 0. Status bits 7, 6 and 5 all clear. No timeout occurs.
- R6: A write to offset 0x10 whose bits 15:8 are not 0x40 sets status bit 7 (bad arming key) and status bit 5 (event).
- R7: A write to offset 0x20 sets status bit 6 (bad confirm key) and status bit 5 in three cases: there was no prior correct arming key, the window is closed, or bits 7:0 are not 0x08.
- R8: Any event, including the count reaching LIMIT_CNT without a clear, raises `timeout_o` for exactly one cycle and restarts the count at 0.
- R9: An event sets the reset-cause bit. It reads as bit 5 at offset 0x80 and drives `rst_cause_o`. It stays set until a clear-alias write with bit 5 at offset 0x80.
- R10: In the cycle after the enable is cleared, writes are ignored and every read returns 0. The timer is off from the next cycle.
- R11: Key writes made while the timer is disabled have no effect on the status flags or on the cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counting event, one per cycle when high |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_op | input | 2 | Write mode: 0 load, 1 set-alias, 2 clear-alias, 3 none |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, same cycle |
| timeout_o | output | 1 | One-cycle event pulse |
| rst_cause_o | output | 1 | Latched reset-cause bit |

## Verification
The hardest states to reach are the ones that depend on where the count sits relative to the window. A confirm key must land exactly inside or exactly outside the window, and the deadline must expire on one precise tick. The stimulus gates `tick` for an exact number of edges, so the count stops on chosen values: 47 and 48 at the window edge, and 63 and then 64 at the limit. Key writes then arrive with the count frozen. The dead cycle after disabling is reached by issuing a write and a read on the two cycles right after the disabling write.

// File: rtl/kwt_pkg.sv
package kwt_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_ARMED, ST_KEYED, ST_HOLD} kwt_state_e;
    typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_SET = 2'd1, OP_CLEAR = 2'd2, OP_NONE = 2'd3} kwt_op_e;

    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ARM   = 8'h10;
    localparam logic [ADDR_W-1:0] A_CONF  = 8'h20;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h30;
    localparam logic [ADDR_W-1:0] A_COUNT = 8'h40;
    localparam logic [ADDR_W-1:0] A_LIMIT = 8'h60;
    localparam logic [ADDR_W-1:0] A_WIN   = 8'h70;
    localparam logic [ADDR_W-1:0] A_CAUSE = 8'h80;

    localparam logic [7:0] ARM_KEY  = 8'h40;
    localparam logic [7:0] CONF_KEY = 8'h08;
    localparam int EN_BIT    = 15;
    localparam int CAUSE_BIT = 5;

    function automatic logic apply_op(input kwt_op_e op, input logic cur, input logic d);
        logic r;
        unique case (op)
            OP_WRITE: r = d;
            OP_SET:   r = cur | d;
            OP_CLEAR: r = cur & ~d;
            default:  r = cur;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/kwt_counter.sv
module kwt_counter #(
    parameter int LIMIT_CNT = 64,
    parameter int WIN_CNT   = 16,
    parameter int CNT_W     = $clog2(LIMIT_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             win_open,
    output logic             limit_hit
);
    localparam logic [CNT_W-1:0] LAST_C      = CNT_W'(LIMIT_CNT - 1);
    localparam logic [CNT_W-1:0] WIN_START_C = CNT_W'(LIMIT_CNT - WIN_CNT);

    assign limit_hit = run && tick && (count == LAST_C);
    assign win_open  = run && (count >= WIN_START_C);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart)
            count <= '0;
        else if (tick)
            count <= (count == LAST_C) ? '0 : count + 1'b1;
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST_C);
    assert_limit_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |=> count == '0);
endmodule

// File: rtl/kwt_keyfsm.sv
module kwt_keyfsm
    import kwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_on,
    input  logic       req_off,
    input  logic       arm_wr,
    input  logic       arm_ok,
    input  logic       conf_wr,
    input  logic       conf_ok,
    input  logic       win_open,
    input  logic       limit_hit,
    output kwt_state_e state,
    output logic       running,
    output logic       fire,
    output logic       good_clear,
    output logic       flag_bad_arm,
    output logic       flag_bad_conf,
    output logic       flag_evt,
    output logic       timeout_q
);
    kwt_state_e nxt;
    logic bad_arm, bad_conf;

    assign running    = (state == ST_ARMED) || (state == ST_KEYED);
    assign good_clear = running && conf_wr && conf_ok && (state == ST_KEYED) && win_open;
    assign bad_arm    = running && arm_wr && !arm_ok;
    assign bad_conf   = running && conf_wr && !good_clear;
    assign fire       = running && !req_off && (bad_arm || bad_conf || (limit_hit && !good_clear));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (req_on) nxt = ST_ARMED;
            ST_ARMED,
            ST_KEYED: begin
                if (req_off)                  nxt = ST_HOLD;
                else if (fire || good_clear)  nxt = ST_ARMED;
                else if (arm_wr && arm_ok)    nxt = ST_KEYED;
            end
            ST_HOLD:  nxt = ST_OFF;
            default:  nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_bad_arm  <= 1'b0;
            flag_bad_conf <= 1'b0;
            flag_evt      <= 1'b0;
            timeout_q     <= 1'b0;
        end else begin
            timeout_q <= fire;
            if (good_clear) begin
                flag_bad_arm  <= 1'b0;
                flag_bad_conf <= 1'b0;
                flag_evt      <= 1'b0;
            end else if (fire) begin
                flag_bad_arm  <= flag_bad_arm | bad_arm;
                flag_bad_conf <= flag_bad_conf | bad_conf;
                flag_evt      <= 1'b1;
            end
        end
    end

    assert_hold_leaves_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HOLD |=> state == ST_OFF);
    assert_event_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> timeout_q && flag_evt);
    assert_clear_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        good_clear |=> !flag_bad_arm && !flag_bad_conf && !flag_evt && !timeout_q);
    assert_keyed_from_armkey_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_KEYED) |-> $past(arm_wr && arm_ok));
endmodule

// File: rtl/kwt_regbus.sv
module kwt_regbus
    import kwt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LIMIT_CNT = 64,
    parameter int WIN_CNT   = 16,
    parameter int CNT_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_op,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hold,
    input  logic              running,
    input  logic              win_open,
    input  logic              fire,
    input  logic              flag_bad_arm,
    input  logic              flag_bad_conf,
    input  logic              flag_evt,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              req_on,
    output logic              req_off,
    output logic              arm_wr,
    output logic              arm_ok,
    output logic              conf_wr,
    output logic              conf_ok,
    output logic              cause_q
);
    kwt_op_e op;
    logic    wr, en_next;

    assign op      = kwt_op_e'(bus_op);
    assign wr      = bus_sel && bus_we && !hold;
    assign en_next = apply_op(op, running, bus_wdata[EN_BIT]);
    assign req_on  = wr && (bus_addr == A_CTRL) && !running && en_next;
    assign req_off = wr && (bus_addr == A_CTRL) && running && !en_next;
    assign arm_wr  = wr && (bus_addr == A_ARM);
    assign arm_ok  = bus_wdata[15:8] == ARM_KEY;
    assign conf_wr = wr && (bus_addr == A_CONF);
    assign conf_ok = bus_wdata[7:0] == CONF_KEY;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= 1'b0;
        else if (fire)
            cause_q <= 1'b1;
        else if (wr && bus_addr == A_CAUSE)
            cause_q <= apply_op(op, cause_q, bus_wdata[CAUSE_BIT]);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && !hold) begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata[EN_BIT] = running;
                A_STAT:  bus_rdata[7:0] = {flag_bad_arm, flag_bad_conf, flag_evt, 4'b0, win_open};
                A_COUNT: bus_rdata = DATA_W'(count);
                A_LIMIT: bus_rdata = DATA_W'(LIMIT_CNT);
                A_WIN:   bus_rdata = DATA_W'(WIN_CNT);
                A_CAUSE: bus_rdata[CAUSE_BIT] = cause_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/keyed_window_timer.sv
module keyed_window_timer
    import kwt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LIMIT_CNT = 64,
    parameter int WIN_CNT   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_op,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timeout_o,
    output logic              rst_cause_o
);
    localparam int CNT_W = $clog2(LIMIT_CNT);

    kwt_state_e       state;
    logic             running, fire, good_clear;
    logic             flag_bad_arm, flag_bad_conf, flag_evt;
    logic             req_on, req_off, arm_wr, arm_ok, conf_wr, conf_ok;
    logic             win_open, limit_hit;
    logic [CNT_W-1:0] count;

    kwt_counter #(.LIMIT_CNT(LIMIT_CNT), .WIN_CNT(WIN_CNT), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(running), .tick(tick),
        .restart(fire || good_clear), .count(count),
        .win_open(win_open), .limit_hit(limit_hit)
    );

    kwt_keyfsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
        .arm_wr(arm_wr), .arm_ok(arm_ok), .conf_wr(conf_wr), .conf_ok(conf_ok),
        .win_open(win_open), .limit_hit(limit_hit), .state(state),
        .running(running), .fire(fire), .good_clear(good_clear),
        .flag_bad_arm(flag_bad_arm), .flag_bad_conf(flag_bad_conf),
        .flag_evt(flag_evt), .timeout_q(timeout_o)
    );

    kwt_regbus #(.DATA_W(DATA_W), .LIMIT_CNT(LIMIT_CNT), .WIN_CNT(WIN_CNT), .CNT_W(CNT_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .hold(state == ST_HOLD), .running(running), .win_open(win_open),
        .fire(fire), .flag_bad_arm(flag_bad_arm), .flag_bad_conf(flag_bad_conf),
        .flag_evt(flag_evt), .count(count), .bus_rdata(bus_rdata),
        .req_on(req_on), .req_off(req_off), .arm_wr(arm_wr), .arm_ok(arm_ok),
        .conf_wr(conf_wr), .conf_ok(conf_ok), .cause_q(rst_cause_o)
    );

    assert_cause_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> rst_cause_o);
    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> !timeout_o);
endmodule

// File: tb/keyed_window_timer_test.sv
module keyed_window_timer_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_op = 2'd0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        timeout_o, rst_cause_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    keyed_window_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .timeout_o(timeout_o), .rst_cause_o(rst_cause_o)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // R2 control aliases, R3 constants, R10 dead cycle, R11 keys while off
    localparam vec_t VECS [0:17] = '{
        '{1'b0, 2'd0, 8'h60, 32'h0,    32'd64},
        '{1'b0, 2'd0, 8'h70, 32'h0,    32'd16},
        '{1'b0, 2'd0, 8'h00, 32'h0,    32'h0},
        '{1'b1, 2'd1, 8'h00, 32'h8000, 32'h0},
        '{1'b0, 2'd0, 8'h00, 32'h0,    32'h8000},
        '{1'b1, 2'd3, 8'h00, 32'h0,    32'h0},
        '{1'b0, 2'd0, 8'h00, 32'h0,    32'h8000},
        '{1'b1, 2'd0, 8'h00, 32'h8000, 32'h0},
        '{1'b0, 2'd0, 8'h00, 32'h0,    32'h8000},
        '{1'b0, 2'd0, 8'h40, 32'h0,    32'h0},
        '{1'b0, 2'd0, 8'h30, 32'h0,    32'h0},
        '{1'b1, 2'd2, 8'h00, 32'h8000, 32'h0},
        '{1'b1, 2'd1, 8'h00, 32'h8000, 32'h0},
        '{1'b0, 2'd0, 8'h00, 32'h0,    32'h0},
        '{1'b1, 2'd0, 8'h10, 32'h4100, 32'h0},
        '{1'b1, 2'd0, 8'h20, 32'h0009, 32'h0},
        '{1'b0, 2'd0, 8'h30, 32'h0,    32'h0},
        '{1'b0, 2'd0, 8'h80, 32'h0,    32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_op = op; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic good_clear();
        step(2'd0, 8'h10, 32'h4000);
        step(2'd0, 8'h20, 32'h0008);
    endtask

    initial begin
        #(CLK_P * 50000);
        n_bad++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h30, 32'h0, "R1 status");
        rd(8'h40, 32'h0, "R1 count");
        rd(8'h80, 32'h0, "R1 cause");
        check("R1 timeout_o", {31'b0, timeout_o}, 32'h0);
        check("R1 rst_cause_o", {31'b0, rst_cause_o}, 32'h0);

        // Vector table, one bus access per cycle
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_we = VECS[i].wr; bus_op = VECS[i].op;
            bus_addr = VECS[i].addr; bus_wdata = VECS[i].data;
            #1;
            if (!VECS[i].wr) check($sformatf("R2/R3/R10/R11 vec %0d", i), bus_rdata, VECS[i].exp);
            @(posedge clk);
            #1 bus_sel = 1'b0; bus_we = 1'b0;
        end
        check("R11 no pulse while off", {31'b0, rst_cause_o}, 32'h0);

        // R3 counting, R4 window boundary
        step(2'd1, 8'h00, 32'h8000);
        ticks(10);
        rd(8'h40, 32'd10, "R3 count after 10 ticks");
        ticks(37);
        rd(8'h30, 32'h0, "R4 window closed at 47");
        ticks(1);
        rd(8'h30, 32'h1, "R4 window open at 48");

        // R5 correct sequence inside window
        good_clear();
        rd(8'h40, 32'h0, "R5 count cleared");
        rd(8'h30, 32'h0, "R5 flags zero");
        check("R5 no timeout", {31'b0, rst_cause_o}, 32'h0);

        // R7 confirm with window closed
        good_clear();
        @(negedge clk);
        check("R7/R8 pulse high", {31'b0, timeout_o}, 32'h1);
        rd(8'h30, 32'h60, "R7 bad confirm flags");
        check("R8 pulse one cycle", {31'b0, timeout_o}, 32'h0);
        rd(8'h80, 32'h20, "R9 cause set");

        // R9 cause cleared only by clear alias
        step(2'd1, 8'h80, 32'h0);
        rd(8'h80, 32'h20, "R9 cause holds");
        step(2'd2, 8'h80, 32'h20);
        rd(8'h80, 32'h0, "R9 cause cleared");
        check("R9 cause pin", {31'b0, rst_cause_o}, 32'h0);

        // R6 wrong arming key
        step(2'd0, 8'h10, 32'h4100);
        rd(8'h30, 32'hE0, "R6 bad arm flag");
        check("R6 cause", {31'b0, rst_cause_o}, 32'h1);
        step(2'd2, 8'h80, 32'h20);

        // R5 flags cleared by a good sequence
        ticks(48);
        good_clear();
        rd(8'h30, 32'h0, "R5 sticky flags cleared");

        // R7 confirm without arming key, window open
        ticks(48);
        step(2'd0, 8'h20, 32'h0008);
        rd(8'h30, 32'h60, "R7 confirm without arm");

        // R7 wrong confirm value in window
        ticks(48);
        good_clear();
        ticks(48);
        step(2'd0, 8'h10, 32'h4000);
        step(2'd0, 8'h20, 32'h0009);
        rd(8'h30, 32'h60, "R7 wrong confirm value");

        // R8 deadline expiry
        ticks(48);
        good_clear();
        step(2'd2, 8'h80, 32'h20);
        ticks(63);
        rd(8'h40, 32'd63, "R8 count before limit");
        check("R8 no pulse at 63", {31'b0, timeout_o}, 32'h0);
        ticks(1);
        @(negedge clk);
        check("R8 pulse at limit", {31'b0, timeout_o}, 32'h1);
        rd(8'h40, 32'h0, "R8 count restarted");
        check("R8 pulse ended", {31'b0, timeout_o}, 32'h0);
        rd(8'h30, 32'h20, "R8 event flag");
        check("R9 cause from deadline", {31'b0, rst_cause_o}, 32'h1);

        // R10 read in dead cycle
        ticks(5);
        step(2'd2, 8'h00, 32'h8000);
        rd(8'h60, 32'h0, "R10 read zero in dead cycle");
        rd(8'h00, 32'h0, "R10 off after dead cycle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule